// File: doc/BRIEF.md
# Reflected CRC-16 Byte Engine

This block keeps a running 16-bit checksum over the bytes of a serial frame: the address, the function code and every data byte, one byte per strobe. It uses the right-shifting, bit-reflected form of the generator, with the tap constant 0xA001 and a start value of 0xFFFF. A clear input restarts the register at the start of each frame.

On transmit, the two result bytes are read from `crcLo` and `crcHi` and sent in that order. On receive, the two checksum bytes that arrive are fed through the engine as well. The register then ends at zero for an intact frame, and `residueOk` reports that.

A parameter selects between two variants. The bit-serial variant spends eight clock cycles on each byte and drops `ready` while it works. The byte-parallel variant folds all eight steps into one cycle and keeps `ready` high.

Top module: `crc16Engine`

## Requirements
- R1: Out of reset the register holds 0xFFFF (`crcLo`=0xFF, `crcHi`=0xFF), `ready` is high and `residueOk` is low.
- R2: `clearIn` high at a clock edge loads 0xFFFF into the register. In the serial variant it also abandons a byte in progress, so `ready` is high one cycle later.
- R3: When `clearIn` and `byteValid` are high in the same cycle, the clear wins and the byte is dropped. The register reads 0xFFFF afterwards.
- R4: An accepted byte is XORed into register bits 7:0. Eight steps follow. In each step the register shifts right by one, and if the bit shifted out (bit 0 before the shift) was 1, the shifted value is XORed with 0xA001.
- R5: `crcLo` is register bits 7:0 and `crcHi` is bits 15:8, in transmit order. After a clear, the bytes 01 03 00 00 00 01 give `crcLo`=0x84 and `crcHi`=0x0A.
- R6: In the serial variant (`SERIAL_MODE`=1), a byte is accepted when `byteValid` and `ready` are high and `clearIn` is low. `ready` is then low for exactly 8 cycles, and the result stands on the outputs when `ready` returns high.
- R7: A `byteValid` strobe while `ready` is low has no effect on the result. With no accepted byte, no step in progress and no clear, the register holds its value.
- R8: In the byte-parallel variant (`SERIAL_MODE`=0), `ready` stays high. The updated checksum appears one cycle after the accepting edge.
- R9: `residueOk` is high exactly when the register is 0x0000. Feeding a frame followed by its own two checksum bytes (low first) sets it. Feeding a corrupted checksum byte leaves it low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| clearIn | input | 1 | Restart the register at 0xFFFF (start of frame) |
| byteValid | input | 1 | Strobe: `byteData` holds a frame byte |
| byteData | input | 8 | Frame byte to fold into the checksum |
| ready | output | 1 | Engine can accept a byte this cycle |
| crcLo | output | 8 | Register bits 7:0, sent first |
| crcHi | output | 8 | Register bits 15:8, sent second |
| residueOk | output | 1 | Register equals zero (receive check) |

## Verification
All inputs change on falling edges and all outputs are sampled on falling edges. A clear or a dropped byte therefore shows on the first falling edge after the rising edge that takes it.

- **Serial instance:** the result is due eight rising edges after the accepting edge. The bench counts falling edges with `ready` low, expects exactly eight, and compares the checksum at the first falling edge where `ready` is high again.
- **Parallel instance:** it runs beside the serial one on its own strobe. It is compared one edge after acceptance.

Both are checked against a bit-by-bit model across every single-byte value, across pseudo-random frames, across the clear and strobe collisions, and across the residue cases.

// File: rtl/crc16_pkg.sv
package crc16_pkg;
  typedef struct packed {
    logic clear;
    logic load;
    logic shift;
  } crcStrobe_t;
endpackage

// File: rtl/crc16Ctrl.sv
module crc16Ctrl
  import crc16_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter bit SERIAL_MODE = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       clearIn,
  input  logic       byteValid,
  output logic       ready,
  output crcStrobe_t strb
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(DATA_W - 1);

  logic accept;
  assign accept = byteValid & ready & ~clearIn;

  generate
    if (SERIAL_MODE) begin : g_serial
      logic busy;
      logic [CNT_W-1:0] stepCnt;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          busy    <= 1'b0;
          stepCnt <= '0;
        end else if (clearIn) begin
          busy    <= 1'b0;
          stepCnt <= '0;
        end else if (accept) begin
          busy    <= 1'b1;
          stepCnt <= '0;
        end else if (busy) begin
          if (stepCnt == LAST_STEP) begin
            busy    <= 1'b0;
            stepCnt <= '0;
          end else begin
            stepCnt <= stepCnt + 1'b1;
          end
        end
      end

      assign ready = ~busy;
      always_comb begin
        strb.clear = clearIn;
        strb.load  = accept;
        strb.shift = busy & ~clearIn;
      end

      assert_last_step_R6: assert property (@(posedge clk) disable iff (!rstN)
        busy && stepCnt == LAST_STEP && !clearIn |=> ready);
      assert_accept_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
        byteValid && ready && !clearIn |=> !ready);
    end else begin : g_parallel
      assign ready = 1'b1;
      always_comb begin
        strb.clear = clearIn;
        strb.load  = accept;
        strb.shift = 1'b0;
      end

      assert_always_ready_R8: assert property (@(posedge clk) disable iff (!rstN)
        byteValid |=> ready);
    end
  endgenerate

  assert_clear_wins_R3: assert property (@(posedge clk) disable iff (!rstN)
    clearIn |=> ready);
endmodule

// File: rtl/crc16Datapath.sv
module crc16Datapath
  import crc16_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CRC_W = 16,
  parameter logic [CRC_W-1:0] POLY = 16'hA001,
  parameter logic [CRC_W-1:0] INIT = 16'hFFFF,
  parameter bit SERIAL_MODE = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  crcStrobe_t       strb,
  input  logic [DATA_W-1:0] byteData,
  output logic [CRC_W-1:0] crcValue
);
  logic [CRC_W-1:0] crcReg;
  logic [CRC_W-1:0] mixed;
  logic [CRC_W-1:0] loadValue;
  logic [CRC_W-1:0] stepValue;

  function automatic logic [CRC_W-1:0] oneStep(input logic [CRC_W-1:0] v);
    return v[0] ? ((v >> 1) ^ POLY) : (v >> 1);
  endfunction

  assign mixed     = crcReg ^ {{(CRC_W-DATA_W){1'b0}}, byteData};
  assign stepValue = oneStep(crcReg);

  generate
    if (SERIAL_MODE) begin : g_xorOnly
      assign loadValue = mixed;
    end else begin : g_fullByte
      always_comb begin
        loadValue = mixed;
        for (int i = 0; i < DATA_W; i++) loadValue = oneStep(loadValue);
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           crcReg <= INIT;
    else if (strb.clear) crcReg <= INIT;
    else if (strb.load)  crcReg <= loadValue;
    else if (strb.shift) crcReg <= stepValue;
  end

  assign crcValue = crcReg;

  assert_clear_init_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> crcValue == INIT);
  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clear && !strb.load && !strb.shift |=> $stable(crcValue));
endmodule

// File: rtl/crc16Engine.sv
module crc16Engine
  import crc16_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CRC_W = 16,
  parameter logic [CRC_W-1:0] POLY = 16'hA001,
  parameter logic [CRC_W-1:0] INIT = 16'hFFFF,
  parameter bit SERIAL_MODE = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clearIn,
  input  logic             byteValid,
  input  logic [DATA_W-1:0] byteData,
  output logic             ready,
  output logic [DATA_W-1:0] crcLo,
  output logic [DATA_W-1:0] crcHi,
  output logic             residueOk
);
  crcStrobe_t strb;
  logic [CRC_W-1:0] crcValue;

  crc16Ctrl #(.DATA_W(DATA_W), .SERIAL_MODE(SERIAL_MODE)) i_ctrl (
    .clk(clk), .rstN(rstN), .clearIn(clearIn), .byteValid(byteValid),
    .ready(ready), .strb(strb)
  );

  crc16Datapath #(.DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(POLY), .INIT(INIT),
                  .SERIAL_MODE(SERIAL_MODE)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .byteData(byteData), .crcValue(crcValue)
  );

  assign crcLo     = crcValue[DATA_W-1:0];
  assign crcHi     = crcValue[2*DATA_W-1:DATA_W];
  assign residueOk = (crcValue == '0);

  assert_ready_after_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
    clearIn |=> ready && !residueOk);
endmodule

// File: tb/test_crc16Engine.sv
module test_crc16Engine;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clearIn = 1'b0;
  logic valS = 1'b0, valP = 1'b0;
  logic [7:0] dataIn = 8'h00;
  logic readyS, readyP, resS, resP;
  logic [7:0] loS, hiS, loP, hiP;
  int tests = 0, fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  crc16Engine #(.SERIAL_MODE(1'b1)) i_crc16Engine (
    .clk(clk), .rstN(rstN), .clearIn(clearIn), .byteValid(valS), .byteData(dataIn),
    .ready(readyS), .crcLo(loS), .crcHi(hiS), .residueOk(resS));
  crc16Engine #(.SERIAL_MODE(1'b0)) i_crc16EnginePar (
    .clk(clk), .rstN(rstN), .clearIn(clearIn), .byteValid(valP), .byteData(dataIn),
    .ready(readyP), .crcLo(loP), .crcHi(hiP), .residueOk(resP));

  function automatic logic [15:0] refByte(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] v = c ^ {8'h00, b};
    for (int i = 0; i < 8; i++) v = v[0] ? ((v >> 1) ^ 16'hA001) : (v >> 1);
    return v;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doClear();
    @(negedge clk); clearIn = 1'b1;
    @(negedge clk); clearIn = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b, output int lowCycles);
    @(negedge clk); dataIn = b; valS = 1'b1; valP = 1'b1;
    @(negedge clk); valS = 1'b0; valP = 1'b0;
    lowCycles = 0;
    while (!readyS) begin lowCycles++; @(negedge clk); end
  endtask

  initial begin
    int n;
    logic [15:0] model;
    logic [7:0] lfsr = 8'h5A;
    logic [7:0] frm [0:7];
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 lo", {loS, hiS}, 16'hFFFF);
    check("R1 par", {loP, hiP}, 16'hFFFF);
    check("R1 ready", {readyS, readyP, resS, resP}, 4'b1100);
    rstN = 1'b1;
    @(negedge clk);

    // R5 known vector 01 03 00 00 00 01 -> 84 0A
    frm = '{8'h01, 8'h03, 8'h00, 8'h00, 8'h00, 8'h01, 8'h84, 8'h0A};
    doClear();
    for (int i = 0; i < 6; i++) begin
      sendByte(frm[i], n);
      check("R6 ready low 8", n, 8);
    end
    check("R5 serial", {loS, hiS}, 16'h840A);
    check("R5 parallel", {loP, hiP}, 16'h840A);
    check("R9 not yet", {resS, resP}, 2'b00);
    sendByte(8'h84, n); sendByte(8'h0A, n);
    check("R9 residue good", {resS, resP}, 2'b11);
    doClear();
    for (int i = 0; i < 6; i++) sendByte(frm[i], n);
    sendByte(8'h84, n); sendByte(8'h0B, n);
    check("R9 residue bad", {resS, resP}, 2'b00);

    // R4 exhaustive single-byte sweep, R8 parallel result and ready
    for (int b = 0; b < 256; b++) begin
      doClear();
      @(negedge clk); dataIn = 8'(b); valS = 1'b1; valP = 1'b1;
      @(negedge clk); valS = 1'b0; valP = 1'b0;
      model = refByte(16'hFFFF, 8'(b));
      check("R8 parallel one cycle", {hiP, loP}, model);
      check("R8 parallel ready", readyP, 1'b1);
      n = 0;
      while (!readyS) begin n++; @(negedge clk); end
      check("R6 serial count", n, 8);
      check("R4 serial byte", {hiS, loS}, model);
    end

    // R4 pseudo-random frames
    for (int f = 0; f < 30; f++) begin
      doClear();
      model = 16'hFFFF;
      for (int k = 0; k < (f % 9) + 1; k++) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        sendByte(lfsr, n);
        model = refByte(model, lfsr);
      end
      check("R4 frame serial", {hiS, loS}, model);
      check("R4 frame parallel", {hiP, loP}, model);
    end

    // R7 strobe while busy is ignored
    doClear();
    @(negedge clk); dataIn = 8'h31; valS = 1'b1;
    @(negedge clk); dataIn = 8'hC7;
    @(negedge clk); valS = 1'b0;
    while (!readyS) @(negedge clk);
    repeat (3) @(negedge clk);
    check("R7 busy strobe dropped", {hiS, loS}, refByte(16'hFFFF, 8'h31));

    // R3 clear and strobe together
    @(negedge clk); clearIn = 1'b1; valS = 1'b1; valP = 1'b1; dataIn = 8'h55;
    @(negedge clk); clearIn = 1'b0; valS = 1'b0; valP = 1'b0;
    check("R3 serial", {hiS, loS, readyS}, {16'hFFFF, 1'b1});
    check("R3 parallel", {hiP, loP}, 16'hFFFF);

    // R2 clear aborts a byte in progress
    @(negedge clk); dataIn = 8'hA5; valS = 1'b1;
    @(negedge clk); valS = 1'b0;
    repeat (3) @(negedge clk);
    clearIn = 1'b1;
    @(negedge clk); clearIn = 1'b0;
    check("R2 abort", {hiS, loS, readyS}, {16'hFFFF, 1'b1});
    repeat (10) @(negedge clk);
    check("R7 idle hold", {hiS, loS, readyS}, {16'hFFFF, 1'b1});

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule